// File: doc/BRIEF.md
# Command-Queued SPI Master

This block is an SPI master that works through a list of transfers without help from a processor. Software fills a sixteen-entry store. Each entry holds a command byte and a transmit word. Software then sets a first and a last index and pulses `go`. The sequencer visits every index from the first to the last, wrapping from 15 to 0. For each entry it drives that entry's chip-select levels, waits a lead delay, clocks out the word MSB first and clocks in the reply, then waits a trail delay. Each reply is stored at the same index as its command, where a combinational read port returns it.

The command byte sets the shape of each transfer on its own. It chooses whether the selects stay asserted after the word, whether the word is eight bits or the global length, whether the trail delay is fixed or programmed, and whether the lead delay is half a clock period or programmed. One run can therefore mix short and long words, and held and released selects. The clock idles low and data is captured on the rising edge.

The slave-select input is watched during a run. If it goes low, the transfer is aborted on the next clock. A sticky fault then blocks new runs until it is cleared.

Top module: `spi_queue_master`

## Requirements
- R1: After reset, `pcs` is 4'b1111, `sck` is 0, and `busy`, `done` and `mode_fault` are 0.
- R2: In the command byte, bit 7 is hold, bit 6 is length select, bit 5 is trail select and bit 4 is lead select. Bits 3:0 are the pin levels driven on `pcs[3:0]` for that transfer. A 0 on a pin asserts it, and several pins may be 0 at once. The pattern appears on the clock edge that accepts `go` or that starts the entry.
- R3: Word length is 8 when bit 6 is 0. When bit 6 is 1, the length comes from `word_bits`: 0 gives 16, 8 to 15 give that many bits, and 1 to 7 give 8.
- R4: Transmit data leaves MSB first, from the low `len` bits of the entry's word. `mosi` is valid before each rising `sck` edge, and `miso` is sampled on that rising edge. The reply is stored right-aligned with its upper bits 0.
- R5: `sck` stays high for `baud_div` clocks and low for `baud_div` clocks, with values below 2 treated as 2.
- R6: The first rising `sck` edge comes D clocks after `pcs` takes the entry's pattern. D is `baud_div` (at least 2) when bit 4 is 0, and `lead_dly` when bit 4 is 1, where 0 means 128.
- R7: The next entry starts, or `done` rises, T clocks after the last falling `sck` edge. T is 17 when bit 5 is 0, and 32 times `post_dly` when bit 5 is 1, where 0 means 8192.
- R8: With hold 0, `pcs` returns to 4'b1111 on the last falling `sck` edge. With hold 1, the pattern stays through the trail delay until the next entry loads. After the final entry it stays until the next run starts.
- R9: Entries run from `start_ptr` to `end_ptr` in increasing index order, wrapping 15 to 0. `busy` stays high from the accepting edge to the edge that sets `done`. `done` is then held until the next accepted `go`.
- R10: `go` has no effect while `busy` or `mode_fault` is high.
- R11: If `ss_n` is low on a clock edge while `busy` is high, that edge ends the run. `busy` goes to 0, `pcs` to 4'b1111 and `sck` to 0, `mode_fault` is set and `done` stays 0. `mode_fault` holds until `fault_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_we | input | 1 | Write strobe for the command store |
| cmd_idx | input | 4 | Entry index written |
| cmd_byte | input | 8 | Command byte written |
| cmd_tx | input | 16 | Transmit word written |
| rx_idx | input | 4 | Entry index read back |
| rx_word | output | 16 | Reply stored at `rx_idx` |
| start_ptr | input | 4 | First entry of a run |
| end_ptr | input | 4 | Last entry of a run |
| word_bits | input | 4 | Global word length for entries with bit 6 set |
| post_dly | input | 8 | Programmed trail delay in units of 32 clocks |
| lead_dly | input | 7 | Programmed lead delay in clocks |
| baud_div | input | 8 | Half period of `sck` in clocks |
| go | input | 1 | Starts a run when idle and not faulted |
| fault_clr | input | 1 | Clears `mode_fault` |
| ss_n | input | 1 | Slave-select input, a low level during a run is a fault |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| pcs | output | 4 | Chip-select pin levels |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |
| mode_fault | output | 1 | Sticky slave-select fault |

## Verification
Every timing result is counted in clock edges from the edge where it starts. `pcs` changes on the edge that accepts `go`. The first rising `sck` comes D edges later, and each `sck` phase lasts `baud_div` edges. `done` follows the last falling `sck` by T edges. A fault shows on the very next edge after `ss_n` is seen low. The bench drives inputs on the falling clock edge and samples one time unit after each rising edge, recording the edge number of every `sck` change and of `done`. Lead, half-period and trail lengths are then exact differences of those numbers. The per-entry select patterns are counted as a number of sampled cycles.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  localparam int DATA_W  = 16;
  localparam int LEN_W   = 5;
  localparam int BAUD_W  = 8;
  localparam int DLY_W   = 14;
  localparam int LEAD_W  = 7;
  localparam int TRAIL_W = 8;
  localparam int BITS_W  = 4;
  localparam int CS_W    = 4;

  typedef struct packed {
    logic            hold;
    logic            wsel;
    logic            tsel;
    logic            lsel;
    logic [CS_W-1:0] cs;
  } cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} seq_t;

  function automatic logic [LEN_W-1:0] word_len(input cmd_t c, input logic [BITS_W-1:0] bits);
    if (!c.wsel)              return LEN_W'(8);
    else if (bits == '0)      return LEN_W'(16);
    else if (bits < BITS_W'(8)) return LEN_W'(8);
    else                      return LEN_W'(bits);
  endfunction

  // returns delay minus one, as loaded into the delay timer
  function automatic logic [DLY_W-1:0] lead_cnt(input cmd_t c, input logic [LEAD_W-1:0] dl,
                                                input logic [BAUD_W-1:0] half);
    if (!c.lsel)         return DLY_W'(half) - DLY_W'(1);
    else if (dl == '0)   return DLY_W'(127);
    else                 return DLY_W'(dl) - DLY_W'(1);
  endfunction

  function automatic logic [DLY_W-1:0] trail_cnt(input cmd_t c, input logic [TRAIL_W-1:0] dt);
    if (!c.tsel)         return DLY_W'(16);
    else if (dt == '0)   return DLY_W'(8191);
    else                 return (DLY_W'(dt) << 5) - DLY_W'(1);
  endfunction
endpackage

// File: rtl/spiq_cmd_store.sv
module spiq_cmd_store #(
  parameter int N_ENTRY = 16,
  parameter int CMD_W   = 8,
  parameter int DW      = 16,
  localparam int AW     = $clog2(N_ENTRY)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CMD_W-1:0] wcmd,
  input  logic [DW-1:0] wtx,
  input  logic [AW-1:0] raddr,
  output logic [CMD_W-1:0] rcmd,
  output logic [DW-1:0] rtx
);
  logic [CMD_W-1:0] cmd_mem [N_ENTRY];
  logic [DW-1:0]    tx_mem  [N_ENTRY];

  for (genvar i = 0; i < N_ENTRY; i++) begin : g_ent
    logic hit;
    assign hit = we && (waddr == AW'(i));
    always_ff @(posedge clk) begin
      if (hit) begin
        cmd_mem[i] <= wcmd;
        tx_mem[i]  <= wtx;
      end
    end
  end

  assign rcmd = cmd_mem[raddr];
  assign rtx  = tx_mem[raddr];
endmodule

// File: rtl/spiq_rx_store.sv
module spiq_rx_store #(
  parameter int N_ENTRY = 16,
  parameter int DW      = 16,
  localparam int AW     = $clog2(N_ENTRY)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [N_ENTRY];

  for (genvar i = 0; i < N_ENTRY; i++) begin : g_ent
    logic hit;
    assign hit = we && (waddr == AW'(i));
    always_ff @(posedge clk) begin
      if (hit) mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spiq_delay.sv
module spiq_delay #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = val;
    else if (cnt_q != '0)  cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/spiq_shifter.sv
module spiq_shifter #(
  parameter int DW = 16,
  parameter int BW = 8,
  localparam int LW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          load,
  input  logic [DW-1:0] tx_word,
  input  logic [LW-1:0] len,
  input  logic          start,
  input  logic [BW-1:0] half,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic [DW-1:0] rx_word,
  output logic          fin
);
  logic [DW-1:0] sh_q, sh_d, rx_q, rx_d;
  logic [LW-1:0] bit_q, bit_d;
  logic [BW-1:0] hc_q, hc_d;
  logic          sck_q, sck_d, act_q, act_d;

  always_comb begin
    sh_d  = sh_q;
    rx_d  = rx_q;
    bit_d = bit_q;
    hc_d  = hc_q;
    sck_d = sck_q;
    act_d = act_q;
    fin   = 1'b0;
    if (abort) begin
      act_d = 1'b0;
      sck_d = 1'b0;
    end else if (load) begin
      sh_d  = tx_word << (LW'(DW) - len);
      rx_d  = '0;
      bit_d = '0;
      act_d = 1'b0;
      sck_d = 1'b0;
    end else if (start) begin
      act_d = 1'b1;
      sck_d = 1'b1;
      rx_d  = {rx_q[DW-2:0], miso};
      hc_d  = half - BW'(1);
      bit_d = '0;
    end else if (act_q) begin
      if (hc_q == '0) begin
        hc_d = half - BW'(1);
        if (sck_q) begin
          sck_d = 1'b0;
          if (bit_q == len - LW'(1)) begin
            act_d = 1'b0;
            fin   = 1'b1;
          end else begin
            sh_d  = sh_q << 1;
            bit_d = bit_q + LW'(1);
          end
        end else begin
          sck_d = 1'b1;
          rx_d  = {rx_q[DW-2:0], miso};
        end
      end else begin
        hc_d = hc_q - BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rx_q  <= '0;
      bit_q <= '0;
      hc_q  <= '0;
      sck_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      rx_q  <= rx_d;
      bit_q <= bit_d;
      hc_q  <= hc_d;
      sck_q <= sck_d;
      act_q <= act_d;
    end
  end

  assign sck     = sck_q;
  assign mosi    = sh_q[DW-1];
  assign rx_word = rx_q;
endmodule

// File: rtl/spi_queue_master.sv
module spi_queue_master
  import spiq_pkg::*;
#(
  parameter int N_ENTRY = 16,
  localparam int AW     = $clog2(N_ENTRY)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_we,
  input  logic [AW-1:0]       cmd_idx,
  input  logic [7:0]          cmd_byte,
  input  logic [DATA_W-1:0]   cmd_tx,
  input  logic [AW-1:0]       rx_idx,
  output logic [DATA_W-1:0]   rx_word,
  input  logic [AW-1:0]       start_ptr,
  input  logic [AW-1:0]       end_ptr,
  input  logic [BITS_W-1:0]   word_bits,
  input  logic [TRAIL_W-1:0]  post_dly,
  input  logic [LEAD_W-1:0]   lead_dly,
  input  logic [BAUD_W-1:0]   baud_div,
  input  logic                go,
  input  logic                fault_clr,
  input  logic                ss_n,
  input  logic                miso,
  output logic                sck,
  output logic                mosi,
  output logic [CS_W-1:0]     pcs,
  output logic                busy,
  output logic                done,
  output logic                mode_fault
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  seq_t             st_q, st_d;
  logic [AW-1:0]    ptr_q, ptr_d, nidx;
  cmd_t             cur_q, cur_d, ncmd;
  logic [LEN_W-1:0] len_q, len_d, nlen, sh_len;
  logic [CS_W-1:0]  pcs_q, pcs_d;
  logic             busy_q, busy_d, done_q, done_d, flt_q, flt_d;
  logic [7:0]       rcmd_raw;
  logic [DATA_W-1:0] ntx, shf_rx;
  logic [BAUD_W-1:0] half;
  logic             dly_load, dly_exp, sh_start, sh_fin, rx_we, abort, nxt_load;
  logic [DLY_W-1:0] dly_val;

  assign half = (baud_div < BAUD_W'(2)) ? BAUD_W'(2) : baud_div;
  assign nidx = (st_q == ST_IDLE) ? start_ptr : ptr_q + AW'(1);
  assign ncmd = cmd_t'(rcmd_raw);
  assign nlen = word_len(ncmd, word_bits);
  assign abort = busy_q && !ss_n;

  spiq_cmd_store #(.N_ENTRY(N_ENTRY), .CMD_W(8), .DW(DATA_W)) u_cmd (
    .clk(clk), .we(cmd_we), .waddr(cmd_idx), .wcmd(cmd_byte), .wtx(cmd_tx),
    .raddr(nidx), .rcmd(rcmd_raw), .rtx(ntx)
  );

  spiq_rx_store #(.N_ENTRY(N_ENTRY), .DW(DATA_W)) u_rx (
    .clk(clk), .we(rx_we), .waddr(ptr_q), .wdata(shf_rx),
    .raddr(rx_idx), .rdata(rx_word)
  );

  spiq_delay #(.W(DLY_W)) u_dly (
    .clk(clk), .rst_n(srst_n), .load(dly_load), .val(dly_val), .expired(dly_exp)
  );

  // entry load strobe, kept apart from the state logic that reads sh_fin
  always_comb begin
    nxt_load = 1'b0;
    if (!abort) begin
      if (st_q == ST_IDLE)
        nxt_load = go && !flt_q;
      else if (st_q == ST_TRAIL)
        nxt_load = dly_exp && (ptr_q != end_ptr);
    end
  end

  assign sh_len = nxt_load ? nlen : len_q;

  spiq_shifter #(.DW(DATA_W), .BW(BAUD_W)) u_shf (
    .clk(clk), .rst_n(srst_n), .abort(abort), .load(nxt_load), .tx_word(ntx),
    .len(sh_len), .start(sh_start), .half(half), .miso(miso),
    .sck(sck), .mosi(mosi), .rx_word(shf_rx), .fin(sh_fin)
  );

  always_comb begin
    st_d     = st_q;
    ptr_d    = ptr_q;
    cur_d    = cur_q;
    len_d    = len_q;
    pcs_d    = pcs_q;
    busy_d   = busy_q;
    done_d   = done_q;
    flt_d    = flt_q;
    dly_load = 1'b0;
    dly_val  = '0;
    sh_start = 1'b0;
    rx_we    = 1'b0;
    if (fault_clr) flt_d = 1'b0;
    if (nxt_load) begin
      st_d     = ST_LEAD;
      ptr_d    = nidx;
      cur_d    = ncmd;
      len_d    = nlen;
      pcs_d    = ncmd.cs;
      busy_d   = 1'b1;
      done_d   = 1'b0;
      dly_load = 1'b1;
      dly_val  = lead_cnt(ncmd, lead_dly, half);
    end else begin
      unique case (st_q)
        ST_LEAD: begin
          if (dly_exp) begin
            st_d     = ST_SHIFT;
            sh_start = 1'b1;
          end
        end
        ST_SHIFT: begin
          if (sh_fin) begin
            st_d     = ST_TRAIL;
            rx_we    = 1'b1;
            dly_load = 1'b1;
            dly_val  = trail_cnt(cur_q, post_dly);
            if (!cur_q.hold) pcs_d = '1;
          end
        end
        ST_TRAIL: begin
          if (dly_exp) begin
            st_d   = ST_IDLE;
            busy_d = 1'b0;
            done_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (abort) begin
      st_d     = ST_IDLE;
      busy_d   = 1'b0;
      done_d   = 1'b0;
      pcs_d    = '1;
      flt_d    = 1'b1;
      rx_we    = 1'b0;
      sh_start = 1'b0;
      dly_load = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      cur_q  <= '0;
      len_q  <= LEN_W'(8);
      pcs_q  <= '1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      flt_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      cur_q  <= cur_d;
      len_q  <= len_d;
      pcs_q  <= pcs_d;
      busy_q <= busy_d;
      done_q <= done_d;
      flt_q  <= flt_d;
    end
  end

  assign pcs        = pcs_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign mode_fault = flt_q;
endmodule

// File: rtl/spiq_checker.sv
module spiq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic       fault_clr,
  input logic       ss_n,
  input logic       sck,
  input logic [3:0] pcs,
  input logic       busy,
  input logic       done,
  input logic       mode_fault
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);                                                           // R11
  AST_FAULT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ss_n |=> !busy && mode_fault && !sck && (pcs == 4'hF) && !done); // R11
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault && !fault_clr |=> mode_fault);                                  // R11
  AST_RUN_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go) && !$past(mode_fault));                          // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                           // R9
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !go |=> done);                                                     // R9
  AST_PCS_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(pcs));                                              // R8
endmodule

bind spi_queue_master spiq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .fault_clr(fault_clr), .ss_n(ss_n),
  .sck(sck), .pcs(pcs), .busy(busy), .done(done), .mode_fault(mode_fault)
);

// File: tb/tb_spi_queue_master.sv
module tb_spi_queue_master;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        cmd_we;
  logic [3:0]  cmd_idx;
  logic [7:0]  cmd_byte;
  logic [15:0] cmd_tx;
  logic [3:0]  rx_idx;
  logic [15:0] rx_word;
  logic [3:0]  start_ptr, end_ptr, word_bits;
  logic [7:0]  post_dly, baud_div;
  logic [6:0]  lead_dly;
  logic        go, fault_clr, ss_n, miso, sck, mosi, busy, done, mode_fault;
  logic [3:0]  pcs;

  int total = 0;
  int bad   = 0;

  spi_queue_master dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_idx(cmd_idx), .cmd_byte(cmd_byte),
    .cmd_tx(cmd_tx), .rx_idx(rx_idx), .rx_word(rx_word), .start_ptr(start_ptr),
    .end_ptr(end_ptr), .word_bits(word_bits), .post_dly(post_dly), .lead_dly(lead_dly),
    .baud_div(baud_div), .go(go), .fault_clr(fault_clr), .ss_n(ss_n), .miso(miso),
    .sck(sck), .mosi(mosi), .pcs(pcs), .busy(busy), .done(done), .mode_fault(mode_fault)
  );

  // slave model: inverted loopback, so the reply is the complement of the sent bits
  assign miso = ~mosi;

  int          mon_bits = 0;
  logic [15:0] mon_word = '0;
  always @(posedge sck) begin
    mon_word <= {mon_word[14:0], mosi};
    mon_bits <= mon_bits + 1;
  end

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] cb, input logic [15:0] tx);
    @(negedge clk);
    cmd_we = 1'b1; cmd_idx = idx; cmd_byte = cb; cmd_tx = tx;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic chk_rx(input logic [3:0] idx, input logic [15:0] exp, input string tag);
    @(negedge clk);
    rx_idx = idx;
    #1;
    chk(rx_word === exp, tag, rx_word, exp);
  endtask

  // run one entry and time everything in edges counted from the accepting edge
  task automatic run_one(input logic [3:0] idx, output int lead, output int half,
                         output int rises, output logic [15:0] word, output int trail,
                         output logic [3:0] pcs_on, output logic [3:0] pcs_end);
    int base, cyc, first_rise, first_fall, last_fall;
    logic prev;
    start_ptr = idx; end_ptr = idx;
    base = mon_bits;
    @(negedge clk) go = 1'b1;
    @(posedge clk); #1;
    go = 1'b0;
    pcs_on = pcs;
    pcs_end = 4'hx;
    cyc = 0; first_rise = -1; first_fall = -1; last_fall = -1; prev = 1'b0;
    while (!done && cyc < 20000) begin
      @(posedge clk); #1;
      cyc++;
      if (sck && !prev && first_rise < 0) first_rise = cyc;
      if (!sck && prev) begin
        if (first_fall < 0) first_fall = cyc;
        last_fall = cyc;
        pcs_end = pcs;
      end
      prev = sck;
    end
    lead  = first_rise;
    half  = first_fall - first_rise;
    trail = cyc - last_fall;
    rises = mon_bits - base;
    word  = mon_word;
  endtask

  task automatic t_reset();
    chk(pcs === 4'hF, "R1 pcs", pcs, 4'hF);
    chk(sck === 1'b0 && busy === 1'b0, "R1 sck/busy", {sck, busy}, 0);
    chk(done === 1'b0 && mode_fault === 1'b0, "R1 done/fault", {done, mode_fault}, 0);
  endtask

  task automatic t_basic8();
    int lead, half, rises, trail;
    logic [15:0] w;
    logic [3:0] pon, pend;
    baud_div = 8'd2;
    wr(4'd0, 8'b0000_1110, 16'h12C5);
    run_one(4'd0, lead, half, rises, w, trail, pon, pend);
    chk(pon === 4'b1110, "R2 pattern on pcs", pon, 4'b1110);
    chk(lead == 2, "R6 lead half period", lead, 2);
    chk(half == 2, "R5 half period 2", half, 2);
    chk(rises == 8, "R3 default 8 bits", rises, 8);
    chk(w[7:0] === 8'hC5, "R4 msb first mosi", w[7:0], 8'hC5);
    chk(trail == 17, "R7 fixed trail 17", trail, 17);
    chk(pend === 4'hF, "R8 release at last fall", pend, 4'hF);
    chk(done === 1'b1 && busy === 1'b0, "R9 done after run", {done, busy}, 2);
    chk_rx(4'd0, 16'h003A, "R4 reply right aligned");
  endtask

  task automatic t_lengths();
    int lead, half, rises, trail;
    logic [15:0] w;
    logic [3:0] pon, pend;
    baud_div = 8'd3; word_bits = 4'd12; lead_dly = 7'd5; post_dly = 8'd2;
    wr(4'd2, 8'b0111_1101, 16'hFA5C);
    run_one(4'd2, lead, half, rises, w, trail, pon, pend);
    chk(lead == 5, "R6 programmed lead", lead, 5);
    chk(half == 3, "R5 half period 3", half, 3);
    chk(rises == 12, "R3 global 12 bits", rises, 12);
    chk(w[11:0] === 12'hA5C, "R4 12 bit word", w[11:0], 12'hA5C);
    chk(trail == 64, "R7 trail 32x2", trail, 64);
    chk_rx(4'd2, 16'h05A3, "R4 12 bit reply");

    baud_div = 8'd1; word_bits = 4'd0; lead_dly = 7'd0; post_dly = 8'd0;
    wr(4'd3, 8'b0111_0000, 16'h8E71);
    run_one(4'd3, lead, half, rises, w, trail, pon, pend);
    chk(pon === 4'b0000, "R2 all selects low", pon, 0);
    chk(lead == 128, "R6 lead zero means 128", lead, 128);
    chk(half == 2, "R5 divisor below 2", half, 2);
    chk(rises == 16, "R3 bits zero means 16", rises, 16);
    chk(w === 16'h8E71, "R4 16 bit word", w, 16'h8E71);
    chk(trail == 8192, "R7 trail zero means 8192", trail, 8192);
    chk_rx(4'd3, 16'h718E, "R4 16 bit reply");

    baud_div = 8'd2; word_bits = 4'd3;
    wr(4'd4, 8'b0100_1110, 16'h00FF);
    run_one(4'd4, lead, half, rises, w, trail, pon, pend);
    chk(rises == 8, "R3 small bits give 8", rises, 8);
  endtask

  task automatic t_queue();
    int n1110, n0101, cyc, base;
    bit busy_gap;
    baud_div = 8'd2;
    wr(4'd14, 8'b0000_1110, 16'h00A5);
    wr(4'd15, 8'b1000_0101, 16'h003C);
    wr(4'd0,  8'b0000_1011, 16'h000F);
    wr(4'd1,  8'b0000_0111, 16'h0081);
    start_ptr = 4'd14; end_ptr = 4'd1;
    base = mon_bits;
    chk(done === 1'b1, "R9 done held before go", done, 1);
    @(negedge clk) go = 1'b1;
    @(posedge clk); #1;
    go = 1'b0;
    chk(done === 1'b0, "R9 done cleared by go", done, 0);
    n1110 = (pcs == 4'b1110) ? 1 : 0;
    n0101 = 0; cyc = 0; busy_gap = 1'b0;
    while (!done && cyc < 2000) begin
      @(posedge clk); #1;
      cyc++;
      if (!done && !busy) busy_gap = 1'b1;
      if (pcs == 4'b1110) n1110++;
      if (pcs == 4'b0101) n0101++;
    end
    chk(!busy_gap, "R9 busy through run", busy_gap, 0);
    chk(n1110 == 32, "R8 release entry select cycles", n1110, 32);
    chk(n0101 == 49, "R8 hold entry select cycles", n0101, 49);
    chk(mon_bits - base == 32, "R9 four entries run", mon_bits - base, 32);
    chk_rx(4'd14, 16'h005A, "R9 entry 14 reply");
    chk_rx(4'd15, 16'h00C3, "R9 entry 15 reply");
    chk_rx(4'd0,  16'h00F0, "R9 wrapped entry 0 reply");
    chk_rx(4'd1,  16'h007E, "R9 wrapped entry 1 reply");
  endtask

  task automatic t_go_busy();
    int base, cyc;
    baud_div = 8'd4;
    wr(4'd5, 8'b0000_1110, 16'h0096);
    start_ptr = 4'd5; end_ptr = 4'd5;
    base = mon_bits;
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    repeat (12) @(negedge clk);
    go = 1'b1;
    @(negedge clk) go = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk); #1;
      cyc++;
    end
    chk(mon_bits - base == 8, "R10 go while busy ignored", mon_bits - base, 8);
    chk_rx(4'd5, 16'h0069, "R10 reply unchanged");
  endtask

  task automatic t_fault();
    int base, cyc;
    baud_div = 8'd4; word_bits = 4'd0;
    wr(4'd6, 8'b0100_1100, 16'hBEEF);
    start_ptr = 4'd6; end_ptr = 4'd6;
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    cyc = 0;
    while (!sck && cyc < 100) begin
      @(posedge clk); #1;
      cyc++;
    end
    @(negedge clk) ss_n = 1'b0;
    @(posedge clk); #1;
    chk(busy === 1'b0 && sck === 1'b0, "R11 abort busy/sck", {busy, sck}, 0);
    chk(pcs === 4'hF && mode_fault === 1'b1, "R11 pcs idle fault set", {pcs, mode_fault}, 5'h1F);
    chk(done === 1'b0, "R11 no done on fault", done, 0);
    @(negedge clk) ss_n = 1'b1;
    base = mon_bits;
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy === 1'b0 && mon_bits == base, "R10 go ignored during fault", busy, 0);
    chk(mode_fault === 1'b1, "R11 fault sticky", mode_fault, 1);
    @(negedge clk) fault_clr = 1'b1;
    @(negedge clk) fault_clr = 1'b0;
    chk(mode_fault === 1'b0, "R11 fault cleared", mode_fault, 0);
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk); #1;
      cyc++;
    end
    chk_rx(4'd6, 16'h4110, "R11 run after clear");
  endtask

  initial begin
    rst_n = 1'b0; cmd_we = 1'b0; cmd_idx = '0; cmd_byte = '0; cmd_tx = '0; rx_idx = '0;
    start_ptr = '0; end_ptr = '0; word_bits = '0; post_dly = '0; lead_dly = '0;
    baud_div = 8'd2; go = 1'b0; fault_clr = 1'b0; ss_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic8();
    t_lengths();
    t_queue();
    t_go_busy();
    t_fault();
    summary();
    $finish;
  end
endmodule